// File: doc/BRIEF.md
# Synchronous Burst Memory Read/Write Output Pipeline

This block models the datapath of a synchronous static memory with byte lanes and the timing with which it drives its data outputs. Each rising clock edge registers a command made of a chip select, an address, a global write, a byte-write enable, per-lane byte strobes and write data. The command is a read, a write or a deselect. Write data is committed to a small behavioural array one edge after capture. Read data leaves the block on a data bus. A companion drive-enable flag marks the cycles in which a real device would drive its pins.

Two static mode inputs shape the output timing. The first mode input selects the read path. In flow-through operation, read data bypasses the output register. In pipelined operation, read data passes through that register and appears one clock later. The second mode input sets how long the bus stays driven after a deselect. In single-cycle deselect, the drive falls when the last read data slot ends. In dual-cycle deselect, the deselect is delayed one more stage, so the last read word stays on the bus for one further cycle. An asynchronous output enable gates the drive at all times. Tying both mode inputs low gives the default behaviour, which is pipelined with single-cycle deselect.

Top module: `ssram_outpipe`

## Requirements
- R1: After reset, and whenever `drive` is low, `drive` = 0 and `rdata` = 0.
- R2: With `mode_flow` = 1, a read captured at edge e drives `rdata` = the stored word and `drive` = 1 during the cycle after edge e, if `oe` = 1.
- R3: With `mode_flow` = 0, a read captured at edge e drives the stored word with `drive` = 1 during the cycle after edge e+1, if `oe` = 1.
- R4: A command with `sel` = 1, `gw_en` = 0 and `bw_en` = 1 is a write in which only the lanes whose `byte_stb[i]` = 1 are updated. Lane i is bits [9i+8:9i] of `wdata` and of the stored word.
- R5: A command with `sel` = 1 and `gw_en` = 1 writes all four lanes, whatever `bw_en` and `byte_stb` hold.
- R6: A write command never sets `drive`. A byte write with no strobe set changes no lane.
- R7: `oe` = 0 forces `drive` = 0 and `rdata` = 0 at once, without waiting for a clock edge.
- R8: With `mode_dual` = 0, `drive` is low in the first data slot that belongs to a deselect (`sel` = 0). That slot is the cycle after its capture edge in flow-through mode, and one cycle later in pipelined mode.
- R9: With `mode_dual` = 1, a read followed by a deselect keeps `drive` = 1 and the same read word on `rdata` for one extra cycle after the read's data slot, and then `drive` falls.
- R10: With both mode inputs low, the block shows the pipelined read latency of R3 and the single-cycle deselect of R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline state |
| mode_flow | input | 1 | 1 = flow-through read output, 0 = pipelined (static) |
| mode_dual | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle deselect (static) |
| sel | input | 1 | Chip select; 0 captures a deselect |
| gw_en | input | 1 | Global write: all lanes |
| bw_en | input | 1 | Byte-write enable, qualified by `byte_stb` |
| byte_stb | input | LANES | Per-lane write strobes |
| addr | input | AW | Word address |
| wdata | input | LANES*LANE_W | Write data, captured with the command |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | LANES*LANE_W | Read data, zero while not driven |
| drive | output | 1 | Bus drive enable for this cycle |

## Verification
The checker verifies the following relations on every cycle:
- the gating of `drive` by `oe`;
- the zeroed bus while `drive` is low;
- the read latency in each read-path mode;
- that no write ever produces drive;
- the single-cycle deselect turn-off point.

The bench scenarios are needed for the rest. They check that the data word is correct after byte-lane and global writes and after read-after-write on the same address. They check the extra hold cycle of dual-cycle deselect and the held word in it. They check that `oe` acts mid-cycle without a clock edge. They also check the outputs in all four mode combinations under random command mixes.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/ssram_cmd_stage.sv
module ssram_cmd_stage
   import ssram_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int AW     = 6,
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             gw_en,
   input  logic             bw_en,
   input  logic [LANES-1:0] byte_stb,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output op_e              s1_op,
   output logic [AW-1:0]    s1_addr,
   output logic [DW-1:0]    s1_wdata,
   output logic [LANES-1:0] s1_mask
);
   op_e              op_d;
   logic [LANES-1:0] mask_d;

   // decode the raw command before the capture register
   always_comb begin
      if (!sel)
         op_d = OP_IDLE;
      else if (gw_en || bw_en)
         op_d = OP_WRITE;
      else
         op_d = OP_READ;

      if (gw_en)
         mask_d = {LANES{1'b1}};
      else if (bw_en)
         mask_d = byte_stb;
      else
         mask_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_op    <= OP_IDLE;
         s1_addr  <= '0;
         s1_wdata <= '0;
         s1_mask  <= '0;
      end else begin
         s1_op    <= op_d;
         s1_addr  <= addr;
         s1_wdata <= wdata;
         s1_mask  <= (op_d == OP_WRITE) ? mask_d : '0;
      end
   end
endmodule

// File: rtl/ssram_lane_array.sv
module ssram_lane_array #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int AW     = 6,
   localparam int DW    = LANES * LANE_W,
   localparam int DEPTH = 1 << AW
) (
   input  logic             clk,
   input  logic [AW-1:0]    addr,
   input  logic             wr_en,
   input  logic [LANES-1:0] wr_mask,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && wr_mask[g])
            mem[addr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = mem[addr];
   end
endmodule

// File: rtl/ssram_out_stage.sv
module ssram_out_stage
   import ssram_pkg::*;
#(
   parameter int DW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_flow,
   input  logic          mode_dual,
   input  logic          oe,
   input  op_e           s1_op,
   input  logic [DW-1:0] arr_data,
   output logic [DW-1:0] dout,
   output logic          drive
);
   logic [DW-1:0] oreg;
   logic          s1_rd, s1_idle;
   logic          s2_rd, s2_idle, s3_rd;
   logic          valid_ft, valid_pl, valid;
   logic [DW-1:0] data_sel;

   assign s1_rd   = (s1_op == OP_READ);
   assign s1_idle = (s1_op == OP_IDLE);

   // the output register doubles as the hold register for the extra
   // dual-deselect cycle in flow-through mode
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oreg    <= '0;
         s2_rd   <= 1'b0;
         s2_idle <= 1'b1;
         s3_rd   <= 1'b0;
      end else begin
         if (s1_rd)
            oreg <= arr_data;
         s2_rd   <= s1_rd;
         s2_idle <= s1_idle;
         s3_rd   <= s2_rd;
      end
   end

   always_comb begin
      valid_ft = s1_rd | (mode_dual & s2_rd & s1_idle);
      valid_pl = s2_rd | (mode_dual & s3_rd & s2_idle);
      valid    = mode_flow ? valid_ft : valid_pl;
      if (mode_flow && s1_rd)
         data_sel = arr_data;
      else
         data_sel = oreg;
   end

   assign drive = valid & oe;
   assign dout  = drive ? data_sel : '0;
endmodule

// File: rtl/ssram_outpipe.sv
module ssram_outpipe
   import ssram_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int AW     = 6,
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_flow,
   input  logic             mode_dual,
   input  logic             sel,
   input  logic             gw_en,
   input  logic             bw_en,
   input  logic [LANES-1:0] byte_stb,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   input  logic             oe,
   output logic [DW-1:0]    rdata,
   output logic             drive
);
   if (LANES < 1 || LANE_W < 1 || AW < 1 || AW > 12) begin : g_bad_cfg
      $error("ssram_outpipe: unsupported LANES/LANE_W/AW");
   end

   op_e              s1_op;
   logic [AW-1:0]    s1_addr;
   logic [DW-1:0]    s1_wdata;
   logic [LANES-1:0] s1_mask;
   logic [DW-1:0]    arr_data;

   ssram_cmd_stage #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_cmd (
      .clk(clk), .rst_n(rst_n), .sel(sel), .gw_en(gw_en), .bw_en(bw_en),
      .byte_stb(byte_stb), .addr(addr), .wdata(wdata),
      .s1_op(s1_op), .s1_addr(s1_addr), .s1_wdata(s1_wdata), .s1_mask(s1_mask)
   );

   ssram_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_arr (
      .clk(clk), .addr(s1_addr), .wr_en(s1_op == OP_WRITE),
      .wr_mask(s1_mask), .wdata(s1_wdata), .rdata(arr_data)
   );

   ssram_out_stage #(.DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n), .mode_flow(mode_flow), .mode_dual(mode_dual),
      .oe(oe), .s1_op(s1_op), .arr_data(arr_data), .dout(rdata), .drive(drive)
   );
endmodule

// File: rtl/ssram_outpipe_chk.sv
module ssram_outpipe_chk #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DW    = LANES * LANE_W
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mode_flow,
   input logic          mode_dual,
   input logic          sel,
   input logic          gw_en,
   input logic          bw_en,
   input logic          oe,
   input logic [DW-1:0] rdata,
   input logic          drive
);
   logic rd_in, wr_in;
   assign rd_in = sel && !gw_en && !bw_en;
   assign wr_in = sel && (gw_en || bw_en);

   assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> !drive);

   assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !drive |-> (rdata == '0));

   assert_ft_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_in && mode_flow) |=> (drive || !oe || !mode_flow));

   assert_pl_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_in && !mode_flow) |=> ##1 (drive || !oe || mode_flow));

   assert_ft_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_in && mode_flow) |=> (!drive || !mode_flow));

   assert_pl_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_in && !mode_flow) |=> ##1 (!drive || mode_flow));

   assert_ft_scd_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && !mode_dual && mode_flow) |=> (!drive || mode_dual || !mode_flow));

   assert_pl_scd_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && !mode_dual && !mode_flow) |=> ##1 (!drive || mode_dual || mode_flow));
endmodule

bind ssram_outpipe ssram_outpipe_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_flow(mode_flow), .mode_dual(mode_dual),
   .sel(sel), .gw_en(gw_en), .bw_en(bw_en), .oe(oe), .rdata(rdata), .drive(drive)
);

// File: tb/tb_ssram_outpipe.sv
`timescale 1ns/1ps
module tb_ssram_outpipe;
   localparam int LANES = 4, LANE_W = 9, AW = 6, DW = 36, DEPTH = 64;

   logic clk = 1'b0;
   logic rst_n;
   logic mode_flow, mode_dual, sel, gw_en, bw_en, oe;
   logic [LANES-1:0] byte_stb;
   logic [AW-1:0]    addr;
   logic [DW-1:0]    wdata;
   logic [DW-1:0]    rdata;
   logic             drive;

   always #4 clk = ~clk;

   ssram_outpipe #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .mode_flow(mode_flow), .mode_dual(mode_dual),
      .sel(sel), .gw_en(gw_en), .bw_en(bw_en), .byte_stb(byte_stb),
      .addr(addr), .wdata(wdata), .oe(oe), .rdata(rdata), .drive(drive)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   // history of captured commands: index 0 = latest capture edge
   bit          h_rd   [3];
   bit          h_idle [3];
   logic [DW-1:0] h_val [3];
   logic [DW-1:0] shadow [DEPTH];

   function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [LANES-1:0] m);
      logic [DW-1:0] r = old_w;
      for (int i = 0; i < LANES; i++)
         if (m[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
      return r;
   endfunction

   function automatic bit exp_drive();
      int l = mode_flow ? 0 : 1;
      return oe && (h_rd[l] || (mode_dual && h_rd[l+1] && h_idle[l]));
   endfunction

   function automatic logic [DW-1:0] exp_data();
      int l = mode_flow ? 0 : 1;
      if (!exp_drive()) return '0;
      return h_rd[l] ? h_val[l] : h_val[l+1];
   endfunction

   task automatic check(input string tag);
      bit            ed = exp_drive();
      logic [DW-1:0] ex = exp_data();
      n_cmp++;
      if (drive !== ed || rdata !== ex) begin
         n_bad++;
         $display("FAIL %s: drive=%0b rdata=%h expected drive=%0b rdata=%h",
                  tag, drive, rdata, ed, ex);
      end
   endtask

   task automatic hist_clear();
      for (int i = 0; i < 3; i++) begin
         h_rd[i] = 0; h_idle[i] = 1; h_val[i] = '0;
      end
   endtask

   // called at a negedge: apply one command, model its capture, check
   task automatic step(input bit s, input bit g, input bit b,
                       input logic [LANES-1:0] st, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input string tag);
      logic [LANES-1:0] m;
      sel = s; gw_en = g; bw_en = b; byte_stb = st; addr = a; wdata = d;
      @(posedge clk);
      for (int i = 2; i > 0; i--) begin
         h_rd[i] = h_rd[i-1]; h_idle[i] = h_idle[i-1]; h_val[i] = h_val[i-1];
      end
      h_rd[0] = s && !g && !b;
      h_idle[0] = !s;
      h_val[0] = h_rd[0] ? shadow[a] : '0;
      if (s && (g || b)) begin
         m = g ? {LANES{1'b1}} : st;
         shadow[a] = lane_merge(shadow[a], d, m);
      end
      @(negedge clk);
      check(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, '0, '0, '0, tag);
   endtask

   function automatic logic [DW-1:0] rnd_word();
      logic [63:0] t = {$urandom, $urandom};
      return t[DW-1:0];
   endfunction

   task automatic set_mode(input bit f, input bit dd);
      idle(3, "R8");
      mode_flow = f; mode_dual = dd;
      hist_clear();
      #1 check("R1");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] w;
      void'($urandom(32'd20240611));
      rst_n = 0; mode_flow = 0; mode_dual = 0; oe = 1;
      sel = 0; gw_en = 0; bw_en = 0; byte_stb = '0; addr = '0; wdata = '0;
      hist_clear();
      for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset");
      rst_n = 1;

      // fill the array with global writes in the default mode
      for (int i = 0; i < DEPTH; i++)
         step(1, 1, 0, '0, i[AW-1:0], rnd_word(), "R5 R10 fill");
      idle(2, "R10");

      // R10 / R3: default mode read latency and single-cycle turn-off
      step(1, 0, 0, '0, 6'd3, '0, "R10 R3");
      step(0, 0, 0, '0, '0, '0, "R10 R3");
      idle(2, "R10 R8");

      // R2 R8: flow-through, single deselect
      set_mode(1, 0);
      step(1, 0, 0, '0, 6'd5, '0, "R2");
      step(1, 0, 0, '0, 6'd6, '0, "R2");
      idle(2, "R8");

      // R9: flow-through, dual deselect keeps the word one more cycle
      set_mode(1, 1);
      step(1, 0, 0, '0, 6'd7, '0, "R9");
      idle(3, "R9");

      // R9: pipelined, dual deselect
      set_mode(0, 1);
      step(1, 0, 0, '0, 6'd9, '0, "R9");
      idle(4, "R9");

      // R4: byte write to lanes 0 and 2 only, then read back
      set_mode(1, 0);
      w = rnd_word();
      step(1, 0, 1, 4'b0101, 6'd10, w, "R4 R6");
      step(1, 0, 0, '0, 6'd10, '0, "R4");
      idle(1, "R4");
      // R6: byte write with no strobe changes nothing
      step(1, 0, 1, 4'b0000, 6'd10, rnd_word(), "R6");
      step(1, 0, 0, '0, 6'd10, '0, "R6");
      idle(1, "R6");
      // R5: global write overrides a single strobe
      step(1, 1, 1, 4'b0001, 6'd11, rnd_word(), "R5");
      step(1, 0, 0, '0, 6'd11, '0, "R5");
      step(1, 1, 0, 4'b0000, 6'd12, rnd_word(), "R5");
      step(1, 0, 0, '0, 6'd12, '0, "R5");
      idle(1, "R5");

      // R7: output enable acts mid-cycle without a clock edge
      set_mode(0, 0);
      step(1, 0, 0, '0, 6'd12, '0, "R7");
      step(0, 0, 0, '0, '0, '0, "R7");
      oe = 0; #1 check("R7 oe low");
      oe = 1; #1 check("R7 oe high");
      idle(2, "R7");

      // random command mixes in all four mode combinations
      for (int mc = 0; mc < 4; mc++) begin
         set_mode(mc[0], mc[1]);
         for (int k = 0; k < 150; k++) begin
            int kind = $urandom % 10;
            oe = ($urandom % 10) != 0;
            if (kind < 4)
               step(1, 0, 0, '0, 6'($urandom % 16), '0, "R2 R3 rnd");
            else if (kind < 6)
               step(1, ($urandom % 4) == 0, 1, 4'($urandom), 6'($urandom % 16),
                    rnd_word(), "R4 R5 R6 rnd");
            else
               step(0, 0, 0, '0, '0, '0, mc[1] ? "R9 rnd" : "R8 rnd");
         end
         oe = 1;
      end

      idle(3, "R8");
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule